// File: doc/BRIEF.md
# SHA Engine Command Sequencer

This block is the register-side front end of a hash accelerator. Software selects one of seven hash variants, fills a one-block message memory with whole 32-bit words and then issues either a "new message" command or a "chain" command. The sequencer hands the block to an external compression core over a request/done handshake. It tells the core how many message words to fetch and whether to begin from the variant's initial hash values or from the state left by the previous block. It also reports a busy flag until the core has written its result back.

The result words sit in a hash memory that software reads over the same word-addressed bus. Only the words that belong to the selected variant's digest are visible. The message memory is never cleared by the block, so a block that repeats earlier words only needs the changed words rewritten. While a block is in flight, every bus write is dropped, so software cannot disturb the block or the variant in use.

Bus word addresses: bits [7:6] select a region (0 control, 1 message, 2 hash) and bits [5:0] give the word index. Control index 0 is the variant, 1 is the new-message command, 2 is the chain command and 3 is the busy flag.

Top module: `sha_seq_top`

## Requirements
- R1: The variant register (control index 0, bits [2:0]) resets to 0. A full write of a value from 0 to 6 is stored. A write of any value of 7 or more leaves the previous value in place.
- R2: With a request, `core_nwords` carries 16 for variants 0, 1 and 2, and 32 for variants 3, 4, 5 and 6.
- R3: A hash-region read at word index i returns the stored result word when i is below the digest word count of the current variant (5, 7, 8, 12, 16, 7, 8 for variants 0 to 6), and returns zero otherwise.
- R4: A full write to control index 1 while idle raises `core_req` with `core_first` = 1.
- R5: A full write to control index 2 while idle raises `core_req` with `core_first` = 0 if some block has completed since reset, and with `core_first` = 1 otherwise.
- R6: `core_req` is a single-cycle pulse in the cycle after the accepting write. `busy` (and bit 0 of control index 3) is 1 from that cycle until the cycle after `core_done`.
- R7: While `busy` is 1, writes to the variant register, the message memory and both command indices have no effect.
- R8: A write whose byte strobes are not all four set has no effect in any region.
- R9: The message memory keeps its contents across blocks. A core read at `core_msg_addr` returns the word in the next cycle.
- R10: A bus read returns its data in the cycle after `bus_re`. Message-region indices of 32 or more read as zero.
- R11: A command write presented in the same cycle as `core_done` is dropped, because `busy` is still set in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write enable |
| bus_re | input | 1 | Bus read enable |
| bus_addr | input | 8 | Word address: region in [7:6], index in [5:0] |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte strobes; only 4'hF writes |
| bus_rdata | output | 32 | Read data, one cycle after bus_re |
| busy | output | 1 | Block in flight |
| core_req | output | 1 | One-cycle compression request |
| core_first | output | 1 | 1: start from initial hash; 0: chain |
| core_mode | output | 3 | Variant for the core |
| core_nwords | output | 7 | Message words in this block |
| core_msg_addr | input | 5 | Core message read address |
| core_msg_data | output | 32 | Message word, one cycle after address |
| core_hw_en | input | 1 | Core result write enable |
| core_hw_addr | input | 4 | Core result word index |
| core_hw_data | input | 32 | Core result word |
| core_done | input | 1 | Core finished the block |

## Verification
The command decoder and the completion path can act in the same clock cycle. This happens when software issues a command exactly as the core raises done. The bench waits until it sees `core_done` high, drives a new-message write into that very cycle, and then judges the outcome. It counts the requests the block emits and reads `busy` a few cycles later: the write must leave no request and the block must sit idle. A following ordinary command must still be accepted.

// File: rtl/sha_seq_pkg.sv
package sha_seq_pkg;
  localparam int DW = 32;

  typedef enum logic [2:0] {
    HM_160     = 3'd0,
    HM_224     = 3'd1,
    HM_256     = 3'd2,
    HM_384     = 3'd3,
    HM_512     = 3'd4,
    HM_512T224 = 3'd5,
    HM_512T256 = 3'd6
  } hmode_e;

  localparam logic [2:0] MODE_MAX = 3'd6;

  // bus regions (upper two address bits)
  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_MSG  = 2'd1;
  localparam logic [1:0] REG_HASH = 2'd2;

  // control word indices
  localparam int CR_MODE  = 0;
  localparam int CR_START = 1;
  localparam int CR_CHAIN = 2;
  localparam int CR_BUSY  = 3;

  // read data source select
  localparam logic [1:0] RS_REG  = 2'd0;
  localparam logic [1:0] RS_MSG  = 2'd1;
  localparam logic [1:0] RS_HASH = 2'd2;
  localparam logic [1:0] RS_ZERO = 2'd3;
endpackage

// File: rtl/sha_seq_mode_dec.sv
module sha_seq_mode_dec
  import sha_seq_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic [2:0]       mode,
  output logic [CNT_W-1:0] blk_words,
  output logic [CNT_W-1:0] dig_words
);
  always_comb begin
    blk_words = CNT_W'(16);
    dig_words = CNT_W'(0);
    case (hmode_e'(mode))
      HM_160:     begin blk_words = CNT_W'(16); dig_words = CNT_W'(5);  end
      HM_224:     begin blk_words = CNT_W'(16); dig_words = CNT_W'(7);  end
      HM_256:     begin blk_words = CNT_W'(16); dig_words = CNT_W'(8);  end
      HM_384:     begin blk_words = CNT_W'(32); dig_words = CNT_W'(12); end
      HM_512:     begin blk_words = CNT_W'(32); dig_words = CNT_W'(16); end
      HM_512T224: begin blk_words = CNT_W'(32); dig_words = CNT_W'(7);  end
      HM_512T256: begin blk_words = CNT_W'(32); dig_words = CNT_W'(8);  end
      default:    begin blk_words = CNT_W'(16); dig_words = CNT_W'(0);  end
    endcase
  end
endmodule

// File: rtl/sha_seq_ram.sv
module sha_seq_ram #(
  parameter int WORDS  = 32,
  parameter int AW     = 5,
  parameter int DW     = 32,
  parameter int NUM_RD = 1
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic [DW-1:0]        wdata,
  input  logic [NUM_RD-1:0]    re,
  input  logic [NUM_RD*AW-1:0] raddr,
  output logic [NUM_RD*DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (re[g]) q <= mem[raddr[g*AW +: AW]];
    end
    assign rdata[g*DW +: DW] = q;
  end
endmodule

// File: rtl/sha_seq_ctrl.sv
module sha_seq_ctrl #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_wr,
  input  logic             chain_wr,
  input  logic             core_done,
  input  logic [CNT_W-1:0] blk_words,
  output logic             busy,
  output logic             core_req,
  output logic             core_first,
  output logic [CNT_W-1:0] core_nwords
);
  logic have_state;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      core_req    <= 1'b0;
      core_first  <= 1'b0;
      core_nwords <= '0;
      have_state  <= 1'b0;
    end else begin
      core_req <= 1'b0;
      if (busy) begin
        if (core_done) begin
          busy       <= 1'b0;
          have_state <= 1'b1;
        end
      end else if (start_wr || chain_wr) begin
        busy        <= 1'b1;
        core_req    <= 1'b1;
        core_first  <= start_wr || !have_state;
        core_nwords <= blk_words;
      end
    end
  end

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst) core_req |=> !core_req); // R6
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst) busy && !core_done |=> busy); // R6
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (rst) busy && core_done |=> !busy); // R6
  AST_FIRST_FRESH: assert property (@(posedge clk) disable iff (rst) core_req && !have_state |-> core_first); // R5
  AST_NWORDS_LEGAL: assert property (@(posedge clk) disable iff (rst) core_req |-> (core_nwords == CNT_W'(16) || core_nwords == CNT_W'(32))); // R2
  AST_CMD_DROPPED: assert property (@(posedge clk) disable iff (rst) busy && (start_wr || chain_wr) |=> !core_req); // R7
endmodule

// File: rtl/sha_seq_top.sv
module sha_seq_top
  import sha_seq_pkg::*;
#(
  parameter  int ADDR_W     = 8,
  parameter  int MSG_WORDS  = 32,
  parameter  int HASH_WORDS = 16,
  localparam int IDX_W      = ADDR_W - 2,
  localparam int MSG_AW     = $clog2(MSG_WORDS),
  localparam int HASH_AW    = $clog2(HASH_WORDS),
  localparam int CNT_W      = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_we,
  input  logic               bus_re,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  input  logic [3:0]         bus_wstrb,
  output logic [DW-1:0]      bus_rdata,
  output logic               busy,
  output logic               core_req,
  output logic               core_first,
  output logic [2:0]         core_mode,
  output logic [CNT_W-1:0]   core_nwords,
  input  logic [MSG_AW-1:0]  core_msg_addr,
  output logic [DW-1:0]      core_msg_data,
  input  logic               core_hw_en,
  input  logic [HASH_AW-1:0] core_hw_addr,
  input  logic [DW-1:0]      core_hw_data,
  input  logic               core_done
);
  localparam logic [CNT_W-1:0] MSG_LIM = CNT_W'(MSG_WORDS);

  // address decode
  logic [1:0]       region;
  logic [IDX_W-1:0] idx;
  logic             full_wr, ctrl_hit, msg_hit, hash_hit, msg_in_range;
  assign region       = bus_addr[ADDR_W-1 -: 2];
  assign idx          = bus_addr[IDX_W-1:0];
  assign full_wr      = bus_we && (bus_wstrb == 4'hF) && !busy;
  assign ctrl_hit     = (region == REG_CTRL);
  assign msg_hit      = (region == REG_MSG);
  assign hash_hit     = (region == REG_HASH);
  assign msg_in_range = ({1'b0, idx} < MSG_LIM);

  // variant register
  logic [2:0] mode_q;
  logic       mode_we, start_wr, chain_wr, msg_we;
  assign mode_we  = full_wr && ctrl_hit && (idx == IDX_W'(CR_MODE)) &&
                    (bus_wdata <= {{(DW-3){1'b0}}, MODE_MAX});
  assign start_wr = full_wr && ctrl_hit && (idx == IDX_W'(CR_START));
  assign chain_wr = full_wr && ctrl_hit && (idx == IDX_W'(CR_CHAIN));
  assign msg_we   = full_wr && msg_hit && msg_in_range;

  always_ff @(posedge clk) begin
    if (rst)          mode_q <= 3'd0;
    else if (mode_we) mode_q <= bus_wdata[2:0];
  end
  assign core_mode = mode_q;

  logic [CNT_W-1:0] blk_words, dig_words;
  sha_seq_mode_dec #(.CNT_W(CNT_W)) u_dec (
    .mode      (mode_q),
    .blk_words (blk_words),
    .dig_words (dig_words)
  );

  sha_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start_wr    (start_wr),
    .chain_wr    (chain_wr),
    .core_done   (core_done),
    .blk_words   (blk_words),
    .busy        (busy),
    .core_req    (core_req),
    .core_first  (core_first),
    .core_nwords (core_nwords)
  );

  // message memory: port 0 for the bus, port 1 for the core
  logic            msg_rd, hash_rd;
  logic [2*DW-1:0] msg_q;
  assign msg_rd = bus_re && msg_hit && msg_in_range;

  sha_seq_ram #(.WORDS(MSG_WORDS), .AW(MSG_AW), .DW(DW), .NUM_RD(2)) u_msg (
    .clk   (clk),
    .we    (msg_we),
    .waddr (idx[MSG_AW-1:0]),
    .wdata (bus_wdata),
    .re    ({1'b1, msg_rd}),
    .raddr ({core_msg_addr, idx[MSG_AW-1:0]}),
    .rdata (msg_q)
  );
  assign core_msg_data = msg_q[2*DW-1:DW];

  // hash result memory, written by the core
  logic [DW-1:0] hash_q;
  assign hash_rd = bus_re && hash_hit && ({1'b0, idx} < dig_words);

  sha_seq_ram #(.WORDS(HASH_WORDS), .AW(HASH_AW), .DW(DW), .NUM_RD(1)) u_hash (
    .clk   (clk),
    .we    (core_hw_en),
    .waddr (core_hw_addr),
    .wdata (core_hw_data),
    .re    (hash_rd),
    .raddr (idx[HASH_AW-1:0]),
    .rdata (hash_q)
  );

  // read path: select and register value captured with the request
  logic [1:0]    rsel_q;
  logic [DW-1:0] regval_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q   <= RS_ZERO;
      regval_q <= '0;
    end else if (bus_re) begin
      regval_q <= '0;
      if (ctrl_hit) begin
        rsel_q <= RS_REG;
        if (idx == IDX_W'(CR_MODE))      regval_q <= {{(DW-3){1'b0}}, mode_q};
        else if (idx == IDX_W'(CR_BUSY)) regval_q <= {{(DW-1){1'b0}}, busy};
      end else if (msg_rd) begin
        rsel_q <= RS_MSG;
      end else if (hash_rd) begin
        rsel_q <= RS_HASH;
      end else begin
        rsel_q <= RS_ZERO;
      end
    end
  end

  always_comb begin
    case (rsel_q)
      RS_REG:  bus_rdata = regval_q;
      RS_MSG:  bus_rdata = msg_q[DW-1:0];
      RS_HASH: bus_rdata = hash_q;
      default: bus_rdata = '0;
    endcase
  end

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst) mode_q <= MODE_MAX); // R1
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst) busy |=> $stable(mode_q)); // R7
  AST_HW_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst) core_hw_en |-> busy); // R6
endmodule

// File: tb/tb_sha_seq_top.sv
module tb_sha_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_MODE  = 8'h00;
  localparam logic [7:0] A_START = 8'h01;
  localparam logic [7:0] A_CHAIN = 8'h02;
  localparam logic [7:0] A_BUSY  = 8'h03;
  localparam logic [7:0] A_MSG   = 8'h40;
  localparam logic [7:0] A_HASH  = 8'h80;

  // {mode[2:0], chain, fill, seed[7:0]}
  localparam logic [12:0] VEC [8] = '{
    {3'd2, 1'b1, 1'b1, 8'h11},
    {3'd2, 1'b1, 1'b0, 8'h00},
    {3'd0, 1'b0, 1'b1, 8'h23},
    {3'd4, 1'b0, 1'b1, 8'h37},
    {3'd6, 1'b1, 1'b0, 8'h00},
    {3'd3, 1'b1, 1'b1, 8'h4C},
    {3'd5, 1'b0, 1'b1, 8'h5A},
    {3'd1, 1'b1, 1'b0, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_wstrb = '0;
  logic [31:0] bus_rdata;
  logic        busy, core_req, core_first;
  logic [2:0]  core_mode;
  logic [6:0]  core_nwords;
  logic [4:0]  core_msg_addr;
  logic [31:0] core_msg_data;
  logic        core_hw_en;
  logic [3:0]  core_hw_addr;
  logic [31:0] core_hw_data;
  logic        core_done;

  int checks = 0;
  int errors = 0;
  int req_cnt = 0;
  logic       obs_first;
  logic [6:0] obs_nwords;
  logic [2:0] obs_mode;
  logic [31:0] msg_sh [32];
  logic        have_state = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sha_seq_top dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb), .bus_rdata(bus_rdata),
    .busy(busy), .core_req(core_req), .core_first(core_first), .core_mode(core_mode),
    .core_nwords(core_nwords), .core_msg_addr(core_msg_addr), .core_msg_data(core_msg_data),
    .core_hw_en(core_hw_en), .core_hw_addr(core_hw_addr), .core_hw_data(core_hw_data),
    .core_done(core_done)
  );

  // request observer
  always @(negedge clk) begin
    if (!rst && core_req) begin
      req_cnt++;
      obs_first  = core_first;
      obs_nwords = core_nwords;
      obs_mode   = core_mode;
    end
  end

  // fixed-latency compression responder
  initial begin
    logic [31:0] acc;
    logic        f;
    int          n;
    core_msg_addr = '0; core_hw_en = 1'b0; core_hw_addr = '0;
    core_hw_data = '0;  core_done = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst && core_req) begin
        f = core_first; n = int'(core_nwords); acc = '0;
        for (int k = 0; k < n; k++) begin
          core_msg_addr = 5'(k);
          @(negedge clk);
          acc = {acc[30:0], acc[31]} ^ core_msg_data;
        end
        for (int j = 0; j < 16; j++) begin
          core_hw_en = 1'b1; core_hw_addr = 4'(j);
          core_hw_data = acc ^ (f ? 32'hF00D0000 : 32'h0000BEEF) ^ 32'(j);
          @(negedge clk);
        end
        core_hw_en = 1'b0;
        core_done = 1'b1;
        @(negedge clk);
        core_done = 1'b0;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    @(negedge clk);
    bus_we = 1'b0; bus_wstrb = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (busy) begin
      errors++;
      $display("FAIL R6 busy stuck actual 1 expected 0");
    end
  endtask

  function automatic int dig_of(input logic [2:0] m);
    case (m)
      3'd0: return 5;
      3'd1: return 7;
      3'd2: return 8;
      3'd3: return 12;
      3'd4: return 16;
      3'd5: return 7;
      default: return 8;
    endcase
  endfunction

  function automatic logic [31:0] fold(input int n);
    logic [31:0] a = '0;
    for (int k = 0; k < n; k++) a = {a[30:0], a[31]} ^ msg_sh[k];
    return a;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R6 watchdog actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd, acc;
    logic [2:0]  m;
    logic        ch, fl, ef;
    logic [7:0]  sd;
    int          nw, c0;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    check("R6 reset busy", 32'(busy), 32'd0);
    check("R6 reset req", 32'(core_req), 32'd0);
    bus_read(A_MODE, rd);  check("R1 reset mode", rd, 32'd0);
    bus_read(A_BUSY, rd);  check("R6 reset busy reg", rd, 32'd0);

    // variant register legality
    bus_write(A_MODE, 32'd5, 4'hF);  bus_read(A_MODE, rd); check("R1 mode 5 stored", rd, 32'd5);
    bus_write(A_MODE, 32'd7, 4'hF);  bus_read(A_MODE, rd); check("R1 mode 7 rejected", rd, 32'd5);
    bus_write(A_MODE, 32'h102, 4'hF); bus_read(A_MODE, rd); check("R1 mode large rejected", rd, 32'd5);

    // partial strobes
    bus_write(A_MODE, 32'd3, 4'b0001); bus_read(A_MODE, rd); check("R8 partial mode write", rd, 32'd5);
    bus_write(A_MSG + 8'd3, 32'hA5A5A5A5, 4'hF); msg_sh[3] = 32'hA5A5A5A5;
    bus_write(A_MSG + 8'd3, 32'h12345678, 4'b0111);
    bus_read(A_MSG + 8'd3, rd); check("R8 partial message write", rd, 32'hA5A5A5A5);
    c0 = req_cnt;
    bus_write(A_START, 32'd1, 4'b1110);
    repeat (3) @(negedge clk);
    check("R8 partial command write", 32'(req_cnt), 32'(c0));
    bus_read(A_MSG + 8'd40, rd); check("R10 message index out of range", rd, 32'd0);

    // table-driven blocks
    for (int v = 0; v < 8; v++) begin
      {m, ch, fl, sd} = VEC[v];
      bus_write(A_MODE, 32'(m), 4'hF);
      nw = (m < 3'd3) ? 16 : 32;
      if (fl) begin
        for (int k = 0; k < nw; k++) begin
          msg_sh[k] = {sd, 8'(k), ~sd, 8'(k * 3)};
          bus_write(A_MSG + 8'(k), msg_sh[k], 4'hF);
        end
      end
      ef  = !ch || !have_state;
      acc = fold(nw);
      bus_write(ch ? A_CHAIN : A_START, 32'd1, 4'hF);
      wait_idle();
      have_state = 1'b1;
      check(ch ? "R5 chain first flag" : "R4 start first flag", 32'(obs_first), 32'(ef));
      check("R2 block words", 32'(obs_nwords), 32'(nw));
      check("R1 core mode", 32'(obs_mode), 32'(m));
      for (int j = 0; j < 16; j++) begin
        bus_read(A_HASH + 8'(j), rd);
        // R9 retained message words feed the fold; R3 masks beyond digest
        check(j < dig_of(m) ? "R9 hash word" : "R3 hash beyond digest", rd,
              (j < dig_of(m)) ? (acc ^ (ef ? 32'hF00D0000 : 32'h0000BEEF) ^ 32'(j)) : 32'd0);
      end
    end

    // writes during busy
    bus_write(A_MODE, 32'd2, 4'hF);
    for (int k = 0; k < 16; k++) begin
      msg_sh[k] = 32'hC0DE0000 + 32'(k);
      bus_write(A_MSG + 8'(k), msg_sh[k], 4'hF);
    end
    c0 = req_cnt;
    bus_write(A_START, 32'd1, 4'hF);
    check("R6 request pulse", 32'(core_req), 32'd1);
    check("R6 busy set", 32'(busy), 32'd1);
    @(negedge clk);
    check("R6 request single cycle", 32'(core_req), 32'd0);
    bus_read(A_BUSY, rd); check("R6 busy register", rd, 32'd1);
    bus_write(A_MODE, 32'd4, 4'hF);
    bus_write(A_MSG, 32'hDEADBEEF, 4'hF);
    bus_write(A_START, 32'd1, 4'hF);
    bus_write(A_CHAIN, 32'd1, 4'hF);
    wait_idle();
    check("R7 commands dropped while busy", 32'(req_cnt), 32'(c0 + 1));
    bus_read(A_MODE, rd); check("R7 mode kept", rd, 32'd2);
    bus_read(A_MSG, rd);  check("R7 message kept", rd, msg_sh[0]);
    bus_read(A_HASH + 8'd2, rd);
    check("R4 start result", rd, fold(16) ^ 32'hF00D0000 ^ 32'd2);

    // command coinciding with core_done
    bus_write(A_START, 32'd1, 4'hF);
    begin
      int n = 0;
      do begin
        @(negedge clk); #1;
        n++;
      end while (!core_done && n < 2000);
    end
    c0 = req_cnt;
    bus_we = 1'b1; bus_addr = A_START; bus_wdata = 32'd1; bus_wstrb = 4'hF;
    @(negedge clk);
    bus_we = 1'b0; bus_wstrb = '0;
    repeat (3) @(negedge clk);
    check("R11 command at done dropped", 32'(req_cnt), 32'(c0));
    check("R11 idle after done", 32'(busy), 32'd0);
    bus_write(A_CHAIN, 32'd1, 4'hF);
    wait_idle();
    check("R11 next command accepted", 32'(req_cnt), 32'(c0 + 1));
    check("R5 chain after completed block", 32'(obs_first), 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule